// File: doc/BRIEF.md
# Clock Source Mode Controller

This block is the control side of a microcontroller's on-chip clock generator. It receives two free-running clocks: a slow internal reference and the fast output of a frequency-locked loop oscillator. A two-bit operating mode selects one of them, or neither. The chosen clock is divided by a programmable power of two and driven out as the system clock. The block also drives the enable for the locked loop and the enable for the reference oscillator, and it holds the trim word applied to the reference.

Software programs the block through a small write port on the loop-clock domain. Address 0 holds the mode, the divider code and the keep-reference-in-stop bit. Address 1 holds the trim word. Moving between sources uses a two-stage synchronised handshake. The old clock is gated off on its low phase before the new one is gated on, and a status output reports the source that is actually driving. A new divider code is adopted only at a divided-clock boundary.

Top module: `clk_mode_ctrl`

## Requirements
- R1: After reset the block is in mode 0. sys_clk runs at the loop clock's rate, loop_en=1, ref_en=1, trim=0x100 and clk_src=2'b10.
- R2: Writing address 0 with wr_data[1:0]=0 (loop engaged) selects the loop clock for sys_clk and sets loop_en=1 and ref_en=1. clk_src settles to 2'b10 (bit 1 set = loop drives, bit 0 set = reference drives).
- R3: Mode 1 (loop bypassed) selects the reference clock for sys_clk and keeps loop_en=1 and ref_en=1. clk_src settles to 2'b01.
- R4: Mode 2 (bypassed, low power) selects the reference clock for sys_clk and sets loop_en=0 and ref_en=1. clk_src settles to 2'b01.
- R5: In mode 3 (stop), sys_clk shows no rising edge and loop_en=0. clk_src settles to 2'b00, and ref_en equals the keep bit wr_data[4] of the mode write.
- R6: The divider code wr_data[3:2]=n makes the sys_clk period equal to the selected source period times 2^n, for n = 0, 1, 2 and 3.
- R7: Writing address 1 loads wr_data[8:0] into trim by the next loop-clock edge. Writes to address 0 leave trim unchanged.
- R8: No high or low phase of sys_clk is shorter than half a loop-clock period, and clk_src never reads 2'b11.
- R9: A new divider code takes effect only on a low phase of the selected clock, at the point where the internal divide counter is zero. The resulting output keeps full-length phases and the new period.
- R10: clk_src changes only once the switch handshake completes. It still shows the old source two loop-clock edges after the mode write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| loop_clk | input | 1 | Loop oscillator clock; also clocks the write port |
| ref_clk | input | 1 | Internal reference clock |
| rst_n | input | 1 | Synchronous active-low reset, held across at least two reference edges |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = mode/divider/keep, 1 = trim |
| wr_data | input | 9 | Write data |
| sys_clk | output | 1 | Divided system clock |
| loop_en | output | 1 | Locked-loop enable |
| ref_en | output | 1 | Reference oscillator enable |
| trim | output | 9 | Reference trim word |
| clk_src | output | 2 | Active source: bit 1 loop, bit 0 reference |

## Verification
The bench builds the block with the default 9-bit trim and 2-bit divider code. That brings the mid-scale trim reset value and every tap up to divide-by-8 within reach. The two input clocks run at the stated 512:1 ratio from unrelated phases, so each switch crosses truly asynchronous domains. The bench visits every mode, including stop with and without the keep bit. Divider changes are made both on the fast loop clock and on the slow reference, and a pulse-width tracker watches sys_clk throughout.

// File: rtl/clk_mode_pkg.sv
// Shared types for the clock source mode controller.
// Assumes: two-bit mode field; decode is purely combinational.
package clk_mode_pkg;

    typedef enum logic [1:0] {
        MODE_ENGAGED   = 2'd0,
        MODE_BYPASS    = 2'd1,
        MODE_BYPASS_LP = 2'd2,
        MODE_STOP      = 2'd3
    } cms_mode_e;

    typedef struct packed {
        logic want_loop;
        logic want_ref;
        logic loop_en;
        logic ref_en;
    } cms_ctrl_t;

    // Map a mode and the stop keep bit to source requests and enables.
    function automatic cms_ctrl_t cms_decode(cms_mode_e mode, logic keep);
        cms_ctrl_t c;
        c = '0;
        unique case (mode)
            MODE_ENGAGED:   begin c.want_loop = 1'b1; c.loop_en = 1'b1; c.ref_en = 1'b1; end
            MODE_BYPASS:    begin c.want_ref  = 1'b1; c.loop_en = 1'b1; c.ref_en = 1'b1; end
            MODE_BYPASS_LP: begin c.want_ref  = 1'b1; c.ref_en  = 1'b1; end
            MODE_STOP:      begin c.ref_en    = keep; end
            default:        c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cms_regs.sv
// Control registers: mode, divider code, stop keep bit and reference trim.
// Assumes: one write per cycle on loop_clk; TRIM_W >= DIV_W + 3.
module cms_regs
    import clk_mode_pkg::*;
#(
    parameter int TRIM_W = 9,
    parameter int DIV_W  = 2,
    parameter logic [TRIM_W-1:0] TRIM_RST = TRIM_W'(1) << (TRIM_W - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [TRIM_W-1:0] wr_data,
    output cms_ctrl_t         ctrl,
    output logic [DIV_W-1:0]  div_code,
    output logic [TRIM_W-1:0] trim_q
);
    localparam int DIV_LSB  = 2;
    localparam int KEEP_BIT = DIV_LSB + DIV_W;

    cms_mode_e mode_q;
    logic      keep_q;

    // Register writes: address 1 is trim, address 0 is mode/divider/keep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_ENGAGED;
            div_code <= '0;
            keep_q   <= 1'b0;
            trim_q   <= TRIM_RST;
        end else if (wr_en) begin
            if (wr_addr) begin
                trim_q <= wr_data;
            end else begin
                mode_q   <= cms_mode_e'(wr_data[1:0]);
                div_code <= wr_data[DIV_LSB +: DIV_W];
                keep_q   <= wr_data[KEEP_BIT];
            end
        end
    end

    // Decode the held mode into requests and enables.
    always_comb ctrl = cms_decode(mode_q, keep_q);

    AST_RESET_ENGAGED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode_q == MODE_ENGAGED && trim_q == TRIM_RST)); // R1
    AST_TRIM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr) |=> (trim_q == $past(wr_data))); // R7
    AST_TRIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_addr) |=> $stable(trim_q)); // R7

endmodule

// File: rtl/cms_clk_switch.sv
// Glitch-free two-source clock switch with a synchronised handshake.
// Each branch syncs the other's gate state, then gates on its own low phase.
// Assumes: want_loop/want_ref exclusive; mode changes spaced until status settles.
module cms_clk_switch (
    input  logic       loop_clk,
    input  logic       ref_clk,
    input  logic       rst_n,
    input  logic       want_loop,
    input  logic       want_ref,
    output logic       mux_clk,
    output logic [1:0] src_status
);
    logic ref_gate, ref_on_m, ref_on_x;
    logic loop_s1, loop_gate, loop_stat;
    logic [1:0] rq_m, rq_x;
    logic ref_s1;

    // Bring the reference gate state into the loop domain.
    always_ff @(posedge loop_clk) begin
        if (!rst_n) {ref_on_m, ref_on_x} <= 2'b00;
        else        {ref_on_m, ref_on_x} <= {ref_gate, ref_on_m};
    end

    // Loop branch request stage: on only if the reference is off.
    always_ff @(posedge loop_clk) begin
        if (!rst_n) loop_s1 <= 1'b1;
        else        loop_s1 <= want_loop & ~ref_on_x;
    end

    // Loop gate changes while the loop clock is low.
    always_ff @(negedge loop_clk) begin
        if (!rst_n) loop_gate <= 1'b1;
        else        loop_gate <= loop_s1;
    end

    // Loop status reflects the completed gate state.
    always_ff @(posedge loop_clk) begin
        if (!rst_n) loop_stat <= 1'b1;
        else        loop_stat <= loop_gate;
    end

    // Bring the request and the loop gate state into the reference domain.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            rq_m <= 2'b00;
            rq_x <= 2'b00;
        end else begin
            rq_m <= {want_ref, loop_gate};
            rq_x <= rq_m;
        end
    end

    // Reference branch request stage: on only if the loop is off.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) ref_s1 <= 1'b0;
        else        ref_s1 <= rq_x[1] & ~rq_x[0];
    end

    // Reference gate changes while the reference clock is low.
    always_ff @(negedge ref_clk) begin
        if (!rst_n) ref_gate <= 1'b0;
        else        ref_gate <= ref_s1;
    end

    assign mux_clk    = (loop_clk & loop_gate) | (ref_clk & ref_gate);
    assign src_status = {loop_stat, ref_on_x};

    AST_ONE_SOURCE: assert property (@(posedge loop_clk) disable iff (!rst_n)
        $onehot0(src_status)); // R8
    AST_STATUS_LAGS: assert property (@(posedge loop_clk) disable iff (!rst_n)
        ($fell(want_loop) && $past(src_status[1])) |-> src_status[1]); // R10

endmodule

// File: rtl/cms_divider.sv
// Power-of-two divider on the switched clock; code changes only at a boundary.
// Assumes: mux_clk runs during reset (the loop gate resets on).
module cms_divider #(
    parameter int DIV_W = 2
) (
    input  logic             mux_clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_code,
    output logic             div_clk
);
    localparam int TAPS  = 1 << DIV_W;
    localparam int CNT_W = TAPS - 1;

    logic [DIV_W-1:0] div_m, div_x, act_div;
    logic [CNT_W-1:0] cnt_q;
    logic [TAPS-1:0]  taps;

    // Synchronise the code into the switched domain and run the counter.
    always_ff @(posedge mux_clk) begin
        if (!rst_n) begin
            div_m <= '0;
            div_x <= '0;
            cnt_q <= '0;
        end else begin
            div_m <= div_code;
            div_x <= div_m;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Adopt a new code on the low phase when every tap is low.
    always_ff @(negedge mux_clk) begin
        if (!rst_n)             act_div <= '0;
        else if (cnt_q == '0)   act_div <= div_x;
    end

    assign taps[0] = mux_clk;
    for (genvar i = 1; i < TAPS; i++) begin : g_tap
        assign taps[i] = cnt_q[i-1];
    end

    assign div_clk = taps[act_div];

    AST_DIV_AT_BOUNDARY: assert property (@(posedge mux_clk) disable iff (!rst_n)
        (cnt_q != '1) |=> $stable(act_div)); // R9

endmodule

// File: rtl/clk_mode_ctrl.sv
// Top of the clock source mode controller: registers, switch and divider.
// Assumes: loop_clk free-running and used as the register clock.
module clk_mode_ctrl
    import clk_mode_pkg::*;
#(
    parameter int TRIM_W = 9,
    parameter int DIV_W  = 2
) (
    input  logic              loop_clk,
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_addr,
    input  logic [TRIM_W-1:0] wr_data,
    output logic              sys_clk,
    output logic              loop_en,
    output logic              ref_en,
    output logic [TRIM_W-1:0] trim,
    output logic [1:0]        clk_src
);
    localparam int KEEP_BIT = 2 + DIV_W;

    cms_ctrl_t        ctrl;
    logic [DIV_W-1:0] div_code;
    logic             mux_clk;

    cms_regs #(.TRIM_W(TRIM_W), .DIV_W(DIV_W)) u_regs (
        .clk(loop_clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .div_code(div_code), .trim_q(trim)
    );

    cms_clk_switch u_switch (
        .loop_clk(loop_clk), .ref_clk(ref_clk), .rst_n(rst_n),
        .want_loop(ctrl.want_loop), .want_ref(ctrl.want_ref),
        .mux_clk(mux_clk), .src_status(clk_src)
    );

    cms_divider #(.DIV_W(DIV_W)) u_div (
        .mux_clk(mux_clk), .rst_n(rst_n), .div_code(div_code), .div_clk(sys_clk)
    );

    assign loop_en = ctrl.loop_en;
    assign ref_en  = ctrl.ref_en;

    AST_ENGAGED_ENABLES: assert property (@(posedge loop_clk) disable iff (!rst_n)
        (wr_en && !wr_addr && wr_data[1:0] == 2'd0) |=> (loop_en && ref_en)); // R2
    AST_BYPASS_ENABLES: assert property (@(posedge loop_clk) disable iff (!rst_n)
        (wr_en && !wr_addr && wr_data[1:0] == 2'd1) |=> (loop_en && ref_en)); // R3
    AST_LOWPOWER_ENABLES: assert property (@(posedge loop_clk) disable iff (!rst_n)
        (wr_en && !wr_addr && wr_data[1:0] == 2'd2) |=> (!loop_en && ref_en)); // R4
    AST_STOP_ENABLES: assert property (@(posedge loop_clk) disable iff (!rst_n)
        (wr_en && !wr_addr && wr_data[1:0] == 2'd3)
        |=> (!loop_en && ref_en == $past(wr_data[KEEP_BIT]))); // R5

endmodule

// File: tb/test_clk_mode_ctrl.sv
`timescale 1ns/1ps
module test_clk_mode_ctrl;
    localparam real LOOP_P = 5.0;
    localparam real REF_P  = 5.0 * 512;

    logic loop_clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, wr_addr = 1'b0;
    logic [8:0] wr_data = '0;
    logic sys_clk, loop_en, ref_en;
    logic [8:0] trim;
    logic [1:0] clk_src;

    int checks = 0, failures = 0;
    int pushed = 0, done_cnt = 0;
    int sys_edges = 0, short_hi = 0, short_lo = 0, both_src = 0;
    real t_rise = 0.0, t_fall = 0.0;
    bit rise_v = 0, fall_v = 0;

    typedef struct {
        string      rq;
        real        period;
        logic [1:0] src;
        logic       len;
        logic       ren;
    } sb_item_t;
    sb_item_t sb_q[$];

    clk_mode_ctrl i_clk_mode_ctrl (
        .loop_clk(loop_clk), .ref_clk(ref_clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .sys_clk(sys_clk),
        .loop_en(loop_en), .ref_en(ref_en), .trim(trim), .clk_src(clk_src)
    );

    always #(LOOP_P/2) loop_clk = ~loop_clk;
    initial begin
        #1.3;
        forever #(REF_P/2) ref_clk = ~ref_clk;
    end

    task automatic chk(string rq, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s act=%0d exp=%0d", rq, what, act, exp);
        end
    endtask

    task automatic chk_real(string rq, string what, real act, real exp);
        checks++;
        if (act - exp > 0.01 || exp - act > 0.01) begin
            failures++;
            $display("FAIL %s %s act=%0.3f exp=%0.3f", rq, what, act, exp);
        end
    endtask

    task automatic report;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Pulse-width and status tracking on sys_clk (R8).
    always @(posedge sys_clk) begin
        sys_edges++;
        if (rst_n && fall_v && ($realtime - t_fall) < 2.4) short_lo++;
        t_rise = $realtime;
        rise_v = rst_n;
    end
    always @(negedge sys_clk) begin
        if (rst_n && rise_v && ($realtime - t_rise) < 2.4) short_hi++;
        t_fall = $realtime;
        fall_v = rst_n;
    end
    always @(negedge loop_clk) if (rst_n && clk_src == 2'b11) both_src++;

    task automatic wr(logic a, logic [8:0] d);
        @(negedge loop_clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge loop_clk);
        wr_en = 1'b0;
    endtask

    // Driver side of the scoreboard: settle, push the expectation, wait for it.
    task automatic expect_after(real settle, string rq, real period,
                                logic [1:0] src, logic len, logic ren);
        sb_item_t it;
        #(settle);
        it.rq = rq; it.period = period; it.src = src; it.len = len; it.ren = ren;
        sb_q.push_back(it);
        pushed++;
        wait (done_cnt == pushed);
    endtask

    // Monitor side: pop each expectation and compare with the outputs.
    initial begin
        sb_item_t it;
        int e0;
        real t0, t1;
        forever begin
            wait (sb_q.size() > 0);
            it = sb_q.pop_front();
            @(negedge loop_clk); #1;
            chk(it.rq, "loop_en", int'(loop_en), int'(it.len));
            chk(it.rq, "ref_en", int'(ref_en), int'(it.ren));
            chk(it.rq, "clk_src", int'(clk_src), int'(it.src));
            if (it.period == 0.0) begin
                e0 = sys_edges;
                #(3*REF_P);
                chk(it.rq, "sys_clk rising edges in stop", sys_edges - e0, 0);
            end else begin
                @(posedge sys_clk); t0 = $realtime;
                @(posedge sys_clk); t1 = $realtime;
                chk_real(it.rq, "sys_clk period", t1 - t0, it.period);
            end
            done_cnt++;
        end
    end

    initial begin
        #(950_000.0);
        checks++; failures++;
        $display("FAIL watchdog expired act=running exp=done");
        report();
    end

    initial begin
        #(3*REF_P);
        @(negedge loop_clk); rst_n = 1'b1;
        @(negedge loop_clk); #1;
        // R1 reset state
        chk("R1", "trim", int'(trim), 9'h100);
        expect_after(LOOP_P*4, "R1", LOOP_P, 2'b10, 1'b1, 1'b1);

        // R7 trim load
        wr(1'b1, 9'h0A5);
        #1;
        chk("R7", "trim after write", int'(trim), 9'h0A5);

        // R6 divider on the loop clock: code 2, then code 3
        wr(1'b0, {5'b0, 2'd2, 2'd0});
        expect_after(REF_P, "R6", LOOP_P*4, 2'b10, 1'b1, 1'b1);
        wr(1'b0, {5'b0, 2'd3, 2'd0});
        expect_after(REF_P, "R6", LOOP_P*8, 2'b10, 1'b1, 1'b1);
        chk("R7", "trim after mode write", int'(trim), 9'h0A5);

        // R3 bypass, with the R10 status-lag check
        wr(1'b0, {5'b0, 2'd0, 2'd1});
        @(negedge loop_clk); #1;
        chk("R10", "clk_src during handshake", int'(clk_src), 2'b10);
        expect_after(16*REF_P, "R3", REF_P, 2'b01, 1'b1, 1'b1);

        // R4 low power, with divide by 2 on the reference (R6)
        wr(1'b0, {5'b0, 2'd1, 2'd2});
        expect_after(16*REF_P, "R4", REF_P*2, 2'b01, 1'b0, 1'b1);

        // R5 stop, keep reference on, then off
        wr(1'b0, {4'b0, 1'b1, 2'd1, 2'd3});
        expect_after(8*REF_P, "R5", 0.0, 2'b00, 1'b0, 1'b1);
        wr(1'b0, {4'b0, 1'b0, 2'd1, 2'd3});
        expect_after(2*REF_P, "R5", 0.0, 2'b00, 1'b0, 1'b0);

        // R2 back to engaged with divide by 2
        wr(1'b0, {5'b0, 2'd1, 2'd0});
        expect_after(2*REF_P, "R2", LOOP_P*2, 2'b10, 1'b1, 1'b1);

        // R9 divider change back to 1 on the running loop clock
        wr(1'b0, {5'b0, 2'd0, 2'd0});
        expect_after(REF_P, "R9", LOOP_P, 2'b10, 1'b1, 1'b1);
        chk("R9", "short high phases", short_hi, 0);

        // R8 glitch-free across every switch above
        chk("R8", "short low phases", short_lo, 0);
        chk("R8", "clk_src read 11", both_src, 0);
        report();
    end
endmodule